// File: doc/BRIEF.md
# Three-Wire Byte Handshake Engine

This block moves bytes between a host and a controller through a single shift data register. The handshake uses three active-low lines. The host drives transfer-in-progress (`tip_n_i`) and transfer-acknowledge (`tack_n_i`). The engine drives transfer-request (`treq_n_o`). A direction input selects the flow. When the host sends, each handshake step copies the shift register into a 16-byte outgoing buffer. When the host receives, each step loads the next queued reply byte into the shift register.

The host advances the transfer by changing either of its two lines while in-progress is low. No shift clock is used. The request line has two jobs: it shows that reply bytes are waiting, and it marks the end of a reply. Each byte step, end of transfer, acknowledge toggle and reply load produces a shift interrupt pulse. The pulse comes a fixed number of clock cycles after the event, or one cycle after it when the port-B direction value is all ones.

The block does not decode packets. When a transfer ends with at least one byte collected, it emits a one-cycle packet-complete strobe with the byte count. The packet can then be read through a separate read port.

Top module: `tri_wire_xfer`

## Requirements
- R1: After reset, `treq_n_o` is 1, `sr_q_o` is 0, `sr_irq_o` and `pkt_done_o` are 0, `pkt_len_o` is 0, and every outgoing buffer entry reads 0.
- R2: While `tip_n_i` is 0, a clock edge where the pair (`tip_n_i`, `tack_n_i`) differs from its value at the previous edge advances exactly one byte. This includes the edge where `tip_n_i` first falls. With the pair unchanged, nothing advances.
- R3: With `dir_send_i` = 1 (host sends), each advance appends the current `sr_q_o` value to the outgoing buffer at the next free index, starting at 0, and raises an interrupt event. Once 16 bytes are held, further advances store nothing and raise no event.
- R4: With `dir_send_i` = 0, each advance loads the next unread reply byte into `sr_q_o` and raises an event. Loading the last byte drives `treq_n_o` to 1. Advances after the reply is exhausted change nothing.
- R5: While `tip_n_i` is 1 at both this and the previous edge, each change of `tack_n_i` copies its new level onto `treq_n_o` and raises an event.
- R6: On the edge where `tip_n_i` rises, an event is always raised. If the collected count is nonzero, `pkt_done_o` pulses for one cycle with `pkt_len_o` equal to that count, which then stays until the next strobe. The count then returns to 0.
- R7: While `tip_n_i` is 1 and no acknowledge toggle applies, `treq_n_o` is driven to 0 whenever unread reply bytes remain.
- R8: When `ddr_b_i` is 8'hFF, `sr_irq_o` pulses in the cycle after the event edge. Otherwise it pulses DELAY_CYC cycles later than that. A delayed event re-arms the full delay, cancelling any pending pulse.
- R9: A `rply_load_i` pulse sets the reply length to `rply_len_i`, resets the read position to entry 0, and raises an event. Entries are written beforehand through `rply_we_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tip_n_i | input | 1 | Transfer in progress from host, active low |
| tack_n_i | input | 1 | Transfer acknowledge from host, active low |
| dir_send_i | input | 1 | 1: host sends bytes, 0: host receives reply |
| ddr_b_i | input | 8 | Port-B direction value; all ones selects immediate interrupt |
| sr_we_i | input | 1 | Host write strobe for the shift register |
| sr_wdata_i | input | 8 | Host write data for the shift register |
| sr_q_o | output | 8 | Shift register contents |
| treq_n_o | output | 1 | Transfer request to host, active low |
| rply_we_i | input | 1 | Reply entry write strobe |
| rply_addr_i | input | 4 | Reply entry index |
| rply_data_i | input | 8 | Reply entry data |
| rply_load_i | input | 1 | Start a new reply of `rply_len_i` bytes |
| rply_len_i | input | 5 | Reply length in bytes |
| out_addr_i | input | 4 | Outgoing buffer read index |
| out_data_o | output | 8 | Outgoing buffer entry at `out_addr_i` |
| pkt_done_o | output | 1 | One-cycle packet-complete strobe |
| pkt_len_o | output | 5 | Byte count of the last completed packet |
| sr_irq_o | output | 1 | Shift interrupt pulse |

## Verification
The bench targets these corner cases:

- **First falling edge of in-progress.** An engine that skipped this edge as a step would lose the first byte of every transfer.
- **Reply exhaustion.** A design that kept stepping past the end would put stale bytes in the shift register, and one that raised the request line a byte late would tell the host the reply was still pending.
- **Outgoing buffer filling up.** A design that wrapped around instead of dropping would overwrite byte 0, and one that still raised interrupts when full would report phantom bytes.
- **Events closer together than the delay.** A design that did not re-arm would fire early and more than once.
- **Acknowledge toggles while idle with a reply waiting.** A design that let the idle rule win would never mirror the acknowledge level onto the request line.

// File: rtl/tri_wire_pkg.sv
package tri_wire_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tw_pair_track.sv
module tw_pair_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tip_n_i,
  input  logic tack_n_i,
  output logic step_o,
  output logic ack_tog_o,
  output logic xfer_end_o
);
  logic tip_q, tack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tip_q  <= 1'b1;
      tack_q <= 1'b1;
    end else begin
      tip_q  <= tip_n_i;
      tack_q <= tack_n_i;
    end
  end

  assign step_o     = !tip_n_i && ((tip_n_i != tip_q) || (tack_n_i != tack_q));
  assign ack_tog_o  = tip_n_i && tip_q && (tack_n_i != tack_q);
  assign xfer_end_o = tip_n_i && !tip_q;
endmodule

// File: rtl/tw_out_buf.sv
module tw_out_buf
  import tri_wire_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  byte_t         data_i,
  input  logic          clr_i,
  input  logic [AW-1:0] rd_addr_i,
  output byte_t         rd_data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  byte_t         mem [DEPTH];
  logic [CW-1:0] cnt_q;

  assign full_o = (cnt_q == CW'(DEPTH));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      mem[cnt_q[AW-1:0]] <= data_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !clr_i) |=> $stable(cnt_o)); // R3
endmodule

// File: rtl/tw_reply_q.sv
module tw_reply_q
  import tri_wire_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  byte_t         wdata_i,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          pop_i,
  output byte_t         cur_o,
  output logic          remain_o,
  output logic          last_o
);
  byte_t         mem [DEPTH];
  logic [CW-1:0] size_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      size_q <= len_i;
      idx_q  <= '0;
    end else if (pop_i && remain_o) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign remain_o = idx_q < size_q;
  assign last_o   = (idx_q + 1'b1) == size_q;
  assign cur_o    = mem[idx_q[AW-1:0]];
endmodule

// File: rtl/tw_irq_delay.sv
module tw_irq_delay #(
  parameter int DELAY_CYC = 30000,
  parameter int DW        = $clog2(DELAY_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic bypass_i,
  output logic irq_o
);
  logic [DW-1:0] cnt_q;
  logic          irq_q;
  logic          arm, fire;

  assign arm  = ev_i && !bypass_i;
  assign fire = (cnt_q == DW'(1)) && !arm;  // re-arm cancels a pending pulse

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= (ev_i && bypass_i) || fire;
      if (arm)               cnt_q <= DW'(DELAY_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign irq_o = irq_q;

  AST_NO_EARLY_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && !bypass_i) |=> !irq_o); // R8
endmodule

// File: rtl/tri_wire_xfer.sv
module tri_wire_xfer
  import tri_wire_pkg::*;
#(
  parameter int REPLY_DEPTH = 16,
  parameter int OUT_DEPTH   = 16,
  parameter int DELAY_CYC   = 30000
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               tip_n_i,
  input  logic                               tack_n_i,
  input  logic                               dir_send_i,
  input  logic [7:0]                         ddr_b_i,
  input  logic                               sr_we_i,
  input  logic [7:0]                         sr_wdata_i,
  output logic [7:0]                         sr_q_o,
  output logic                               treq_n_o,
  input  logic                               rply_we_i,
  input  logic [$clog2(REPLY_DEPTH)-1:0]     rply_addr_i,
  input  logic [7:0]                         rply_data_i,
  input  logic                               rply_load_i,
  input  logic [$clog2(REPLY_DEPTH+1)-1:0]   rply_len_i,
  input  logic [$clog2(OUT_DEPTH)-1:0]       out_addr_i,
  output logic [7:0]                         out_data_o,
  output logic                               pkt_done_o,
  output logic [$clog2(OUT_DEPTH+1)-1:0]     pkt_len_o,
  output logic                               sr_irq_o
);
  localparam int RAW = $clog2(REPLY_DEPTH);
  localparam int RCW = $clog2(REPLY_DEPTH + 1);
  localparam int OAW = $clog2(OUT_DEPTH);
  localparam int OCW = $clog2(OUT_DEPTH + 1);

  logic           step, ack_tog, xfer_end;
  logic           ob_full;
  logic [OCW-1:0] ob_cnt;
  byte_t          rq_cur;
  logic           rq_remain, rq_last;
  logic           pop, ev_tx, ev_any;
  byte_t          sr_q;
  logic           treq_q, pkt_done_q;
  logic [OCW-1:0] pkt_len_q;

  tw_pair_track u_pair (
    .clk_i, .rst_ni, .tip_n_i, .tack_n_i,
    .step_o(step), .ack_tog_o(ack_tog), .xfer_end_o(xfer_end)
  );

  tw_out_buf #(.DEPTH(OUT_DEPTH), .AW(OAW), .CW(OCW)) u_obuf (
    .clk_i, .rst_ni,
    .push_i(step && dir_send_i), .data_i(sr_q), .clr_i(xfer_end),
    .rd_addr_i(out_addr_i), .rd_data_o(out_data_o),
    .cnt_o(ob_cnt), .full_o(ob_full)
  );

  tw_reply_q #(.DEPTH(REPLY_DEPTH), .AW(RAW), .CW(RCW)) u_rply (
    .clk_i, .rst_ni,
    .we_i(rply_we_i), .waddr_i(rply_addr_i), .wdata_i(rply_data_i),
    .load_i(rply_load_i), .len_i(rply_len_i), .pop_i(pop),
    .cur_o(rq_cur), .remain_o(rq_remain), .last_o(rq_last)
  );

  assign ev_tx  = step && dir_send_i && !ob_full;
  assign pop    = step && !dir_send_i && rq_remain;
  assign ev_any = ev_tx || pop || ack_tog || xfer_end || rply_load_i;

  tw_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
    .clk_i, .rst_ni, .ev_i(ev_any), .bypass_i(ddr_b_i == 8'hFF), .irq_o(sr_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      treq_q     <= 1'b1;
      pkt_done_q <= 1'b0;
      pkt_len_q  <= '0;
    end else begin
      if (pop)            sr_q <= rq_cur;
      else if (sr_we_i)   sr_q <= sr_wdata_i;

      if (pop && rq_last)              treq_q <= 1'b1;
      else if (ack_tog)                treq_q <= tack_n_i;
      else if (tip_n_i && rq_remain)   treq_q <= 1'b0;

      pkt_done_q <= xfer_end && (ob_cnt != '0);
      if (xfer_end && (ob_cnt != '0)) pkt_len_q <= ob_cnt;
    end
  end

  assign sr_q_o     = sr_q;
  assign treq_n_o   = treq_q;
  assign pkt_done_o = pkt_done_q;
  assign pkt_len_o  = pkt_len_q;

  AST_REPLY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && rq_last && !rply_load_i) |=> treq_n_o); // R4
  AST_ACK_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_tog |=> (treq_n_o == $past(tack_n_i))); // R5
  AST_PKT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> (ob_cnt == '0)); // R6
  AST_IDLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_n_i && !ack_tog && rq_remain) |=> !treq_n_o); // R7
endmodule

// File: tb/tri_wire_xfer_bench.sv
module tri_wire_xfer_bench;
  localparam int D = 20;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tip = 1'b1, tack = 1'b1, dir = 1'b0;
  logic [7:0] ddr = 8'h00;
  logic       sr_we = 1'b0;
  logic [7:0] sr_wd = 8'h00;
  logic       r_we = 1'b0, r_load = 1'b0;
  logic [3:0] r_addr = '0, o_addr = '0;
  logic [7:0] r_data = '0;
  logic [4:0] r_len = '0;
  logic [7:0] sr_q, o_data;
  logic       treq_n, pdone, irq;
  logic [4:0] plen;

  tri_wire_xfer #(.DELAY_CYC(D)) u_tri_wire_xfer (
    .clk_i(clk), .rst_ni(rst_n), .tip_n_i(tip), .tack_n_i(tack),
    .dir_send_i(dir), .ddr_b_i(ddr), .sr_we_i(sr_we), .sr_wdata_i(sr_wd),
    .sr_q_o(sr_q), .treq_n_o(treq_n), .rply_we_i(r_we), .rply_addr_i(r_addr),
    .rply_data_i(r_data), .rply_load_i(r_load), .rply_len_i(r_len),
    .out_addr_i(o_addr), .out_data_o(o_data), .pkt_done_o(pdone),
    .pkt_len_o(plen), .sr_irq_o(irq)
  );

  always #5 clk = ~clk;

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  // reference model
  logic [7:0] m_omem [16];
  logic [7:0] m_rmem [16];
  int  m_ocnt, m_rsize, m_ridx, m_dcnt, m_plen;
  bit  m_ptip, m_ptack, m_treq, m_irq, m_pdone, ev, popped;
  logic [7:0] m_sr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptip = 1; m_ptack = 1; m_treq = 1; m_sr = 0; m_ocnt = 0;
      m_rsize = 0; m_ridx = 0; m_dcnt = 0; m_irq = 0; m_pdone = 0; m_plen = 0;
      for (int i = 0; i < 16; i++) begin m_omem[i] = 0; m_rmem[i] = 0; end
    end else begin
      ev = 0; m_irq = 0; m_pdone = 0; popped = 0;
      if (!tip) begin
        if (tip != m_ptip || tack != m_ptack) begin
          if (dir) begin
            if (m_ocnt < 16) begin m_omem[m_ocnt] = m_sr; m_ocnt++; ev = 1; end
          end else if (m_ridx < m_rsize) begin
            m_sr = m_rmem[m_ridx]; m_ridx++; popped = 1; ev = 1;
            if (m_ridx >= m_rsize) m_treq = 1;
          end
        end
      end else if (m_ptip && tack != m_ptack) begin
        m_treq = tack; ev = 1;
      end else begin
        if (!m_ptip) begin
          ev = 1;
          if (m_ocnt > 0) begin m_pdone = 1; m_plen = m_ocnt; end
          m_ocnt = 0;
        end
        if (m_ridx < m_rsize) m_treq = 0;
      end
      if (sr_we && !popped) m_sr = sr_wd;
      if (r_we) m_rmem[r_addr] = r_data;
      if (r_load) begin m_rsize = r_len; m_ridx = 0; ev = 1; end
      if (ev && ddr != 8'hFF) m_dcnt = D;
      else begin
        if (m_dcnt == 1) m_irq = 1;
        if (m_dcnt > 0) m_dcnt--;
      end
      if (ev && ddr == 8'hFF) m_irq = 1;
      m_ptip = tip; m_ptack = tack;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  // compare every cycle, 2 ns after the active edge
  always @(posedge clk) begin
    cyc++;
    #2;
    if (rst_n) begin
      chk("treq_n", treq_n, m_treq);
      chk("sr", sr_q, m_sr);
      chk("irq", irq, m_irq);
      chk("pkt_done", pdone, m_pdone);
      chk("pkt_len", plen, m_plen);
      chk("out_data", o_data, m_omem[o_addr]);
    end
  end

  initial begin
    @(posedge clk);
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL watchdog %s: actual hung expected done", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_reply(int len, logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      r_we = 1; r_addr = 4'(i); r_data = base + 8'(i); tick();
    end
    r_we = 0; r_load = 1; r_len = 5'(len); tick();
    r_load = 0;
  endtask

  task automatic send_bytes(int n, logic [7:0] base, int gap);
    for (int i = 0; i < n; i++) begin
      sr_we = 1; sr_wd = base + 8'(i); tick();
      sr_we = 0;
      if (i == 0) tip = 0; else tack = ~tack;
      tick(gap);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    // R1: reset state, including every outgoing entry
    cur_req = "R1";
    for (int a = 0; a < 16; a++) begin o_addr = 4'(a); tick(); end
    o_addr = 0;
    // R9: reply load, delayed interrupt; R7: idle request low
    cur_req = "R9";
    load_reply(3, 8'hA1);
    cur_req = "R7";
    tick(D + 5);
    // R2: first falling edge of tip is a step, steady pair holds
    cur_req = "R2";
    tip = 0; tick(4);
    // R4: remaining steps, end-of-reply request, exhausted steps ignored
    cur_req = "R4";
    for (int i = 0; i < 4; i++) begin tack = ~tack; tick(3); end
    tick(D + 5);
    // R6: end of transfer with nothing collected
    cur_req = "R6";
    tip = 1; tick(D + 5);
    // R5: idle acknowledge toggles, bypass interrupt
    cur_req = "R5";
    ddr = 8'hFF;
    for (int i = 0; i < 3; i++) begin tack = ~tack; tick(2); end
    load_reply(2, 8'h55);
    for (int i = 0; i < 3; i++) begin tack = ~tack; tick(3); end
    // R3: host sends 18 bytes, last two dropped
    cur_req = "R3";
    dir = 1;
    send_bytes(18, 8'h10, 2);
    cur_req = "R6";
    tip = 1; tick(3);
    cur_req = "R3";
    for (int a = 0; a < 16; a++) begin o_addr = 4'(a); tick(); end
    // R8: delayed mode, events closer than the delay re-arm it
    cur_req = "R8";
    ddr = 8'h00;
    send_bytes(3, 8'hC0, 4);
    tick(D + 5);
    cur_req = "R6";
    tip = 1; tick(D + 5);
    for (int a = 0; a < 4; a++) begin o_addr = 4'(a); tick(); end
    cur_req = "R8";
    tack = ~tack; tick(D + 5);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule